// File: doc/BRIEF.md
# DMA Completion Interrupt Control Register

This block holds the 32-bit interrupt control word of a multi-channel DMA engine. Software writes it to set per-channel enables, a global enable and a bus-error force bit. Software also clears completion flags by writing ones to them. The DMA engine sends a one-cycle completion strobe per channel. A strobe on an enabled channel sets that channel's flag.

After every write or completion strobe, the block checks a combined condition: the global enable together with any raised flag, or the bus-error force bit on its own. The result goes to a self-kept "sent" bit. The block raises a one-cycle request toward bit 3 of the system interrupt status register. It does so only when the condition becomes true while "sent" was still clear. While the condition stays true, no further requests follow.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After synchronous reset, the whole register reads 0 and `irq_req` is 0.
- R2: A write loads bits 5:0, bit 15 and bits 23:16 directly from `wr_data`. Bits 14:6 always read 0.
- R3: Flag bits 30:24 are write-one-to-clear. A flag survives a write only if it was set and the written bit is 0. Writing 0 to a flag leaves it unchanged.
- R4: A strobe on `ch_done[n]` sets flag bit 24+n only if enable bit 16+n was set before that cycle. A strobe on a disabled channel leaves the flag unchanged.
- R5: If a strobe sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R6: On each cycle with a write or any strobe, the block evaluates the condition (bit 23 and any flag in 30:24) or bit 15, using the updated values. Bit 31 takes the result of that evaluation. On any other cycle, bit 31 holds its value.
- R7: `irq_req` goes high in the cycle in which the register shows the evaluated result. It does so only when the condition is true and bit 31 was 0 just before.
- R8: `irq_req` is never high for two cycles in a row.
- R9: In a cycle with neither a write nor a strobe, the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value written by software |
| ch_done | input | NUM_CH | Per-channel completion strobes |
| rd_data | output | 32 | Current register contents |
| irq_req | output | 1 | One-cycle request to set system interrupt status bit 3 |

## Verification
The bench builds the block with `NUM_CH` = 7, so every flag and enable position from bit 16 to bit 30 is live. With all seven positions live, random acknowledges and strobes reach every channel. The directed cases cover three situations: bus-error forcing, a strobe and an acknowledge on the same flag in one cycle, and the clearing of "sent" when a write removes the condition. Random traffic then re-raises the condition many times, which exercises the rule that only the first assertion produces a request.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
  localparam int          REG_W    = 32;
  localparam int          MAX_CH   = 7;
  localparam int          FLAG_LSB = 24;
  localparam int          EN_LSB   = 16;
  localparam int          GEN_BIT  = 23;
  localparam int          BERR_BIT = 15;
  localparam int          SENT_BIT = 31;
  localparam logic [31:0] CFG_MASK = 32'h00FF_803F;
endpackage

// File: rtl/dicr_cfg_reg.sv
// Write-masked configuration field: everything software owns outright.
module dicr_cfg_reg
  import dicr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_d,
  output logic [REG_W-1:0] cfg_q
);
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data & CFG_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end
endmodule

// File: rtl/dicr_flag_bank.sv
// Per-channel completion flags: hardware set wins over write-one-to-clear.
module dicr_flag_bank #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] ack,
  input  logic [NUM_CH-1:0] done,
  input  logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] flag_d,
  output logic [NUM_CH-1:0] flag_q
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic clr, set;
    assign clr = wr_en & ack[n];
    assign set = done[n] & en[n];
    assign flag_d[n] = set | (flag_q[n] & ~clr);

    always_ff @(posedge clk) begin
      if (rst) flag_q[n] <= 1'b0;
      else     flag_q[n] <= flag_d[n];
    end
  end
endmodule

// File: rtl/dicr_master.sv
// Master condition, self-kept sent bit and first-assertion request pulse.
module dicr_master #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval,
  input  logic              gen_en,
  input  logic              berr,
  input  logic [NUM_CH-1:0] flags,
  output logic              sent_q,
  output logic              irq_q
);
  logic cond;
  assign cond = (gen_en & (|flags)) | berr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= eval & cond & ~sent_q;
      if (eval) sent_q <= cond;
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [NUM_CH-1:0] ch_done,
  output logic [31:0]       rd_data,
  output logic              irq_req
);
  localparam int FLAG_MSB = FLAG_LSB + NUM_CH - 1;
  localparam int EN_MSB   = EN_LSB + NUM_CH - 1;

  logic [REG_W-1:0]  cfg_d, cfg_q;
  logic [NUM_CH-1:0] flag_d, flag_q;
  logic              sent_q;
  logic              eval;

  dicr_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  dicr_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .ack(wr_data[FLAG_MSB:FLAG_LSB]),
    .done(ch_done),
    .en(cfg_q[EN_MSB:EN_LSB]),
    .flag_d(flag_d), .flag_q(flag_q)
  );

  assign eval = wr_en | (|ch_done);

  dicr_master #(.NUM_CH(NUM_CH)) u_master (
    .clk(clk), .rst(rst), .eval(eval),
    .gen_en(cfg_d[GEN_BIT]), .berr(cfg_d[BERR_BIT]),
    .flags(flag_d), .sent_q(sent_q), .irq_q(irq_req)
  );

  always_comb begin
    rd_data = cfg_q;
    rd_data[FLAG_MSB:FLAG_LSB] = flag_q;
    rd_data[SENT_BIT] = sent_q;
  end
endmodule

// File: rtl/dicr_checker.sv
module dicr_checker #(
  parameter int NUM_CH = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [NUM_CH-1:0] ch_done,
  input logic [31:0]       rd_data,
  input logic              irq_req
);
  localparam logic [31:0] MASK = 32'h00FF_803F;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[14:6] == '0);                                            // R2
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_data & MASK) == ($past(wr_data) & MASK)));        // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ch_done == '0) |=> ((rd_data[30:24] & $past(wr_data[30:24])) == '0)); // R3
  AST_IRQ_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (rd_data[31] && !$past(rd_data[31])));              // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);                                           // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && ch_done == '0) |=> $stable(rd_data));                 // R9
endmodule

bind dma_irq_ctrl dicr_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .ch_done(ch_done), .rd_data(rd_data), .irq_req(irq_req)
);

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] ch_done = '0;
  logic [31:0]    rd_data;
  logic           irq_req;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] m_cfg;
  logic [6:0]  m_flag;
  logic        m_sent, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ch_done(ch_done), .rd_data(rd_data), .irq_req(irq_req)
  );

  function automatic logic [31:0] model_word();
    return m_cfg | {1'b0, m_flag, 24'h0} | {m_sent, 31'h0};
  endfunction

  // Spec model, applied once per clock edge.
  task automatic model_step(input logic we, input logic [31:0] wd, input logic [6:0] dn);
    logic [6:0]  nflag;
    logic [31:0] ncfg;
    logic        ev, cond;
    nflag = (m_flag & ~(we ? wd[30:24] : 7'h0)) | (dn & m_cfg[22:16]);
    ncfg  = we ? (wd & 32'h00FF_803F) : m_cfg;
    ev    = we | (|dn);
    cond  = (ncfg[23] & (|nflag)) | ncfg[15];
    m_irq = ev & cond & ~m_sent;
    if (ev) m_sent = cond;
    m_flag = nflag;
    m_cfg  = ncfg;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e;
    e = model_word();
    chk("R2 cfg",      rd_data & 32'h00FF_803F, e & 32'h00FF_803F);
    chk("R2 reserved", {23'h0, rd_data[14:6]}, 32'h0);
    chk("R3,R4,R5 flags", {25'h0, rd_data[30:24]}, {25'h0, e[30:24]});
    chk("R6 sent",     {31'h0, rd_data[31]}, {31'h0, e[31]});
    chk("R7 irq",      {31'h0, irq_req}, {31'h0, m_irq});
  endtask

  task automatic cyc(input logic we, input logic [31:0] wd, input logic [6:0] dn);
    wr_en = we; wr_data = wd; ch_done = dn;
    @(posedge clk);
    model_step(we, wd, dn);
    @(negedge clk);
    wr_en = 1'b0; ch_done = '0;
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cfg = '0; m_flag = '0; m_sent = 1'b0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset irq", {31'h0, irq_req}, 32'h0);

    // R2, R6, R7: all-ones write forces bus error, first request
    cyc(1'b1, 32'hFFFF_FFFF, 7'h0);
    chk("R2 load", rd_data, 32'h80FF_803F);
    chk("R7 first irq", {31'h0, irq_req}, 32'h1);
    // R8, R9: idle cycle, pulse ends, word held
    cyc(1'b0, 32'h0, 7'h0);
    chk("R8 pulse ends", {31'h0, irq_req}, 32'h0);
    chk("R9 idle hold", rd_data, 32'h80FF_803F);
    // R7: condition stays true, no new request
    cyc(1'b1, 32'h0000_8000, 7'h0);
    chk("R7 no repeat", {31'h0, irq_req}, 32'h0);
    // R6: enables only, no condition, sent clears
    cyc(1'b1, 32'h007F_0000, 7'h0);
    chk("R6 sent cleared", {31'h0, rd_data[31]}, 32'h0);
    // R5: strobe and acknowledge on channel 2 in the same cycle
    cyc(1'b1, 32'h047F_0000, 7'h04);
    chk("R5 set wins", {31'h0, rd_data[26]}, 32'h1);
    // R4: disabled channel strobe ignored
    cyc(1'b1, 32'h0000_0000, 7'h0);
    cyc(1'b0, 32'h0, 7'h10);
    chk("R4 disabled", {25'h0, rd_data[30:24]}, 32'h04);
    // R3: write one clears, write zero keeps
    cyc(1'b1, 32'h0000_0000, 7'h0);
    chk("R3 zero keeps", {31'h0, rd_data[26]}, 32'h1);
    cyc(1'b1, 32'h0400_0000, 7'h0);
    chk("R3 one clears", {31'h0, rd_data[26]}, 32'h0);
    // R6, R7: global enable with strobe raises request via hardware
    cyc(1'b1, 32'h00FF_0000, 7'h0);
    cyc(1'b0, 32'h0, 7'h01);
    chk("R7 hw irq", {31'h0, irq_req}, 32'h1);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic        we;
      logic [31:0] wd;
      logic [6:0]  dn;
      we = ($urandom % 3) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[15] = 1'b0;
      if (($urandom % 2) != 0) wd[30:24] = wd[30:24] & $urandom;
      dn = (($urandom % 4) == 0) ? 7'($urandom) : 7'h0;
      cyc(we, wd, dn);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule